// File: doc/BRIEF.md
# GPIO Interrupt Sense Unit

This unit watches 32 already-synchronised general-purpose pin inputs and turns level changes into latched interrupt events. Each pin owns a two-bit sense field that selects whether it reacts to any change, to rising changes only, to falling changes only, or to nothing. The sense fields for the lower sixteen pins live in one 32-bit configuration word and those for the upper sixteen pins in a second word. Inside each word the lowest-numbered pin sits in the topmost bit pair.

Latched events are gathered in a pending register that software clears by writing ones. A mask register selects which pending events may raise the single combined interrupt line. A simple write strobe with a byte offset and a registered read port give access to the four registers. Driving the pins, choosing their direction and synchronising them belong to the surrounding port logic.

Top module: `gis_sense_unit`

## Requirements
- R1: During and after synchronous reset, the pending register, the mask register and both sense words hold zero and `irq_o` is low.
- R2: Pin n with n < 16 takes its sense code from the word at offset 0x14, bits [2*(15-n)+1 : 2*(15-n)]. Pin n with n >= 16 takes it from the word at offset 0x18, bits [2*(31-n)+1 : 2*(31-n)].
- R3: Sense code 2'b00 latches an event on every change of the pin, in either direction.
- R4: Sense code 2'b01 latches rising changes only (0 to 1). Sense code 2'b10 latches falling changes only (1 to 0).
- R5: Sense code 2'b11 latches nothing for that pin.
- R6: Pin n is input `pin_i[n]` and owns bit 31-n of the pending register (`event_o`). A qualifying change becomes visible in `event_o` at the first rising clock edge that samples the new pin level.
- R7: A write to offset 0x0C clears every pending bit written as 1 and leaves the bits written as 0 untouched. A qualifying change that arrives in the same cycle as the clear of its bit wins, and the bit stays set.
- R8: The mask register at offset 0x10 uses the same bit order as the pending register, where 1 enables the bit. `irq_o` equals the OR of pending AND mask, and it updates at the same clock edge as those registers.
- R9: One cycle after `addr` is presented, `rdata` holds the register at that offset (0x0C, 0x10, 0x14 or 0x18), or zero for any other offset. A sense word reads back exactly as last written.
- R10: The pin levels sampled in the first cycle after reset become the baseline, so no event is latched for pins that were already high at reset release.
- R11: A pending bit stays set until software clears it, even after the pin goes back to its earlier level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Synchronised pin levels, pin n on bit n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for `addr` |
| event_o | output | 32 | Pending events, pin 0 on bit 31 |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench covers the split between the two sense words at pins 0, 15, 16 and 31. A design that swapped the halves or the pair order inside a word would latch the wrong pins on the mixed-code vectors. A pin held high through reset must produce no spurious event; a design that compared against the reset value would flag all 32 pins. A clear written in the same cycle as a new change must not drop that change, partial clears must leave the unwritten bits alone, and a rising-only pin must keep its event after it falls back. The bench also checks that `irq_o` follows only the masked bits, including a mask that hits nothing but pin 16.

// File: rtl/gis_pkg.sv
package gis_pkg;

  typedef enum logic [1:0] {
    SNS_BOTH = 2'b00,
    SNS_RISE = 2'b01,
    SNS_FALL = 2'b10,
    SNS_NONE = 2'b11
  } sense_e;

  localparam int OFS_EVENT  = 'h0C;
  localparam int OFS_MASK   = 'h10;
  localparam int OFS_SNS_LO = 'h14;
  localparam int OFS_SNS_HI = 'h18;

endpackage

// File: rtl/gis_field_decode.sv
// Pulls the two-bit sense code of every pin out of the two configuration words.
module gis_field_decode #(
  parameter int PINS    = 32,
  parameter int FIELD_W = 2
) (
  input  logic [PINS-1:0]              cfg_lo,
  input  logic [PINS-1:0]              cfg_hi,
  output logic [PINS-1:0][FIELD_W-1:0] mode
);
  localparam int HALF = PINS / 2;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    if (i < HALF) begin : g_lo
      // lower pin numbers sit in the upper bit pairs
      assign mode[i] = cfg_lo[FIELD_W*(HALF-1-i) +: FIELD_W];
    end else begin : g_hi
      assign mode[i] = cfg_hi[FIELD_W*(HALF-1-(i-HALF)) +: FIELD_W];
    end
  end
endmodule

// File: rtl/gis_edge_det.sv
// Compares each pin with its previous sample and qualifies the change by its sense code.
module gis_edge_det
  import gis_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PINS-1:0]        pin_i,
  input  logic [PINS-1:0][1:0]   mode,
  output logic [PINS-1:0]        det
);
  logic [PINS-1:0] pin_q;
  logic            base_vld;
  logic [PINS-1:0] rise;
  logic [PINS-1:0] fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q    <= '0;
      base_vld <= 1'b0;
    end else begin
      pin_q    <= pin_i;
      base_vld <= 1'b1;
    end
  end

  assign rise = pin_i & ~pin_q & {PINS{base_vld}};
  assign fall = ~pin_i & pin_q & {PINS{base_vld}};

  for (genvar i = 0; i < PINS; i++) begin : g_det
    always_comb begin
      case (sense_e'(mode[i]))
        SNS_BOTH: det[i] = rise[i] | fall[i];
        SNS_RISE: det[i] = rise[i];
        SNS_FALL: det[i] = fall[i];
        default:  det[i] = 1'b0;
      endcase
    end

    // R5: reserved code never reports a change
    a_r5_reserved_silent: assert property (@(posedge clk) disable iff (rst)
      (mode[i] == 2'b11) |-> !det[i]);
    // R4: rising-only reports only while the pin is high
    a_r4_rise_only: assert property (@(posedge clk) disable iff (rst)
      ((mode[i] == 2'b01) && det[i]) |-> pin_i[i]);
    // R4: falling-only reports only while the pin is low
    a_r4_fall_only: assert property (@(posedge clk) disable iff (rst)
      ((mode[i] == 2'b10) && det[i]) |-> !pin_i[i]);
    // R3: any-change mode reports when the pin differs from last cycle
    a_r3_both_edges: assert property (@(posedge clk) disable iff (rst)
      ((mode[i] == 2'b00) && base_vld && (pin_i[i] != pin_q[i])) |-> det[i]);
  end
endmodule

// File: rtl/gis_event_bank.sv
// Pending events with write-one-to-clear, the mask and the combined interrupt.
module gis_event_bank #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] set,
  input  logic            clr_en,
  input  logic [PINS-1:0] clr,
  input  logic            mask_we,
  input  logic [PINS-1:0] mask_wdata,
  output logic [PINS-1:0] ev_q,
  output logic [PINS-1:0] mask_q,
  output logic            irq_q
);
  logic [PINS-1:0] ev_d;
  logic [PINS-1:0] mask_d;

  always_comb begin
    ev_d   = (ev_q & ~(clr_en ? clr : '0)) | set;
    mask_d = mask_we ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q   <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ev_q   <= ev_d;
      mask_q <= mask_d;
      irq_q  <= |(ev_d & mask_d);
    end
  end

  // R8: the interrupt line mirrors the masked pending bits
  a_r8_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(ev_q & mask_q));
  // R11: without a clear, no pending bit is lost
  a_r11_event_held: assert property (@(posedge clk) disable iff (rst)
    !clr_en |=> ((ev_q & $past(ev_q)) == $past(ev_q)));
  // R7: cleared bits with no new change go to zero
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (clr_en && ((clr & set) == '0)) |=> ((ev_q & $past(clr)) == '0));
  // R7: a change in the clear cycle survives
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((ev_q & $past(set)) == $past(set)));
endmodule

// File: rtl/gis_sense_unit.sv
module gis_sense_unit
  import gis_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS-1:0]   pin_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   rdata,
  output logic [PINS-1:0]   event_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_EVENT  = ADDR_W'(OFS_EVENT);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_SNS_LO = ADDR_W'(OFS_SNS_LO);
  localparam logic [ADDR_W-1:0] A_SNS_HI = ADDR_W'(OFS_SNS_HI);

  logic [PINS-1:0]        cfg_lo_q;
  logic [PINS-1:0]        cfg_hi_q;
  logic [PINS-1:0][1:0]   mode;
  logic [PINS-1:0]        det;
  logic [PINS-1:0]        det_reg;
  logic [PINS-1:0]        ev_q;
  logic [PINS-1:0]        mask_q;
  logic                   irq_q;
  logic [PINS-1:0]        rdata_q;
  logic                   clr_en;
  logic                   mask_we;

  assign clr_en  = wr_en && (addr == A_EVENT);
  assign mask_we = wr_en && (addr == A_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
    end else if (wr_en) begin
      if (addr == A_SNS_LO) cfg_lo_q <= wdata;
      if (addr == A_SNS_HI) cfg_hi_q <= wdata;
    end
  end

  gis_field_decode #(.PINS(PINS), .FIELD_W(2)) u_decode (
    .cfg_lo (cfg_lo_q),
    .cfg_hi (cfg_hi_q),
    .mode   (mode)
  );

  gis_edge_det #(.PINS(PINS)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .pin_i (pin_i),
    .mode  (mode),
    .det   (det)
  );

  // pin n lands on register bit PINS-1-n
  for (genvar i = 0; i < PINS; i++) begin : g_rev
    assign det_reg[PINS-1-i] = det[i];
  end

  gis_event_bank #(.PINS(PINS)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .set        (det_reg),
    .clr_en     (clr_en),
    .clr        (wdata),
    .mask_we    (mask_we),
    .mask_wdata (wdata),
    .ev_q       (ev_q),
    .mask_q     (mask_q),
    .irq_q      (irq_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (addr)
        A_EVENT:  rdata_q <= ev_q;
        A_MASK:   rdata_q <= mask_q;
        A_SNS_LO: rdata_q <= cfg_lo_q;
        A_SNS_HI: rdata_q <= cfg_hi_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata   = rdata_q;
  assign event_o = ev_q;
  assign irq_o   = irq_q;

  // R9: a sense word holds what was written to it
  a_r9_lo_written: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == A_SNS_LO)) |=> (cfg_lo_q == $past(wdata)));
  a_r9_hi_written: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == A_SNS_HI)) |=> (cfg_hi_q == $past(wdata)));
  // R1: reset leaves everything at zero
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> ((event_o == '0) && !irq_o));
endmodule

// File: tb/gis_sense_unit_tb_top.sv
module gis_sense_unit_tb_top;
  localparam logic [4:0] T_EVENT = 5'h0C;
  localparam logic [4:0] T_MASK  = 5'h10;
  localparam logic [4:0] T_LO    = 5'h14;
  localparam logic [4:0] T_HI    = 5'h18;

  // each entry: sense lo, sense hi, pins before, pins after, mask
  localparam int NVEC = 7;
  localparam logic [159:0] VEC [NVEC] = '{
    {32'h00000000, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'h00000000},
    {32'h55555555, 32'h55555555, 32'hFFFF0000, 32'h0000FFFF, 32'h00000001},
    {32'hAAAAAAAA, 32'hAAAAAAAA, 32'hFFFF0000, 32'h0000FFFF, 32'h00008000},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {32'h1B1B1B1B, 32'hE4E4E4E4, 32'hA5A5A5A5, 32'h5A5A5A5A, 32'hFFFFFFFF},
    {32'hC0000000, 32'h00000003, 32'h00000000, 32'hFFFFFFFF, 32'h80000001},
    {32'h80000000, 32'h00000002, 32'hFFFFFFFF, 32'h00000000, 32'h00000000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_i = '1;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] event_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gis_sense_unit dut_i (
    .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .event_o(event_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] model(input logic [31:0] lo, input logic [31:0] hi,
                                        input logic [31:0] b, input logic [31:0] a);
    logic [31:0] m = '0;
    for (int n = 0; n < 32; n++) begin
      logic [1:0] code;
      logic r, f, hit;
      code = (n < 16) ? lo[2*(15-n) +: 2] : hi[2*(31-n) +: 2];
      r = a[n] & ~b[n];
      f = ~a[n] & b[n];
      case (code)
        2'b00:   hit = r | f;
        2'b01:   hit = r;
        2'b10:   hit = f;
        default: hit = 1'b0;
      endcase
      m[31-n] = hit;
    end
    return m;
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [4:0] a, input logic [31:0] exp);
    addr = a;
    step(1);
    check(req, rdata, exp);
  endtask

  initial begin
    @(negedge clk);
    step(3);
    // R1: reset state
    check("R1 event in reset", event_o, 32'h0);
    check("R1 irq in reset", {31'h0, irq_o}, 32'h0);
    rst = 1'b0;
    step(3);
    // R10: pins high at release are the baseline
    check("R10 no event at release", event_o, 32'h0);
    rd_check("R1 sense lo zero", T_LO, 32'h0);
    rd_check("R1 sense hi zero", T_HI, 32'h0);
    rd_check("R1 mask zero", T_MASK, 32'h0);

    // table walk: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] lo, hi, b, a, m, exp;
      {lo, hi, b, a, m} = VEC[v];
      wr(T_LO, lo);
      wr(T_HI, hi);
      wr(T_MASK, m);
      pin_i = b;
      step(2);
      wr(T_EVENT, 32'hFFFFFFFF);
      check("R7 cleared before vector", event_o, 32'h0);
      pin_i = a;
      step(1);
      exp = model(lo, hi, b, a);
      check("R2 R3 R4 R5 R6 vector events", event_o, exp);
      check("R8 vector irq", {31'h0, irq_o}, {31'h0, |(exp & m)});
    end

    // R9: readback and unknown offset
    wr(T_LO, 32'h12345678);
    wr(T_HI, 32'h9ABCDEF0);
    rd_check("R9 sense lo readback", T_LO, 32'h12345678);
    rd_check("R9 sense hi readback", T_HI, 32'h9ABCDEF0);
    wr(T_MASK, 32'h00F0000F);
    rd_check("R9 mask readback", T_MASK, 32'h00F0000F);
    rd_check("R9 unknown offset", 5'h04, 32'h0);

    // R7: partial clear
    wr(T_LO, 32'h0); wr(T_HI, 32'h0); wr(T_MASK, 32'h0);
    pin_i = 32'h0; step(2);
    wr(T_EVENT, 32'hFFFFFFFF);
    pin_i = 32'hFFFFFFFF; step(1);
    check("R3 all pins toggled", event_o, 32'hFFFFFFFF);
    rd_check("R9 event readback", T_EVENT, 32'hFFFFFFFF);
    wr(T_EVENT, 32'h0000FFFF);
    check("R7 partial clear", event_o, 32'hFFFF0000);

    // R8: mask hitting nothing pending, then only pin 16
    wr(T_MASK, 32'h0000FFFF);
    check("R8 masked off", {31'h0, irq_o}, 32'h0);
    wr(T_EVENT, 32'hFFFFFFFF);
    pin_i = 32'h0; step(1);
    wr(T_EVENT, 32'hFFFF7FFF);
    wr(T_MASK, 32'h00008000);
    check("R8 pin16 only", event_o, 32'h00008000);
    check("R8 irq from pin16", {31'h0, irq_o}, 32'h1);
    wr(T_EVENT, 32'h00008000);
    check("R8 irq drops on clear", {31'h0, irq_o}, 32'h0);

    // R7: change in the clear cycle wins
    wr(T_MASK, 32'h0);
    wr_en = 1'b1; addr = T_EVENT; wdata = 32'hC0000000;
    pin_i = 32'h00000001;
    step(1);
    wr_en = 1'b0;
    check("R7 set beats clear", event_o, 32'h80000000);

    // R11 and R4: rising-only pin 0 keeps its event after falling back
    wr(T_LO, 32'h40000000);
    pin_i = 32'h0; step(2);
    wr(T_EVENT, 32'hFFFFFFFF);
    pin_i = 32'h00000001; step(1);
    check("R4 rise on pin0", event_o, 32'h80000000);
    pin_i = 32'h0; step(3);
    check("R11 held after fall", event_o, 32'h80000000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule